// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block drives a multiplexed external memory bus from a clock that runs at the oscillator rate. Time is divided into machine cycles of twelve clocks. Each machine cycle splits into two six-clock slots. In a fetch machine cycle, each slot emits one address-latch pulse and one program-read strobe, and returns the instruction byte that the memory drove onto the shared low port.

A client can ask for one data access per machine cycle. The access is a read or a write, and uses either a full-width address or a short form. In the short form the high port shows a separately supplied high-port register value. A granted access replaces a whole fetch machine cycle. That cycle has a single latch pulse, no program-read strobes, and one long read or write strobe.

The low port is shared between address and data. The block therefore gives an output-enable alongside the value, and releases the port whenever the external memory must drive it. Captured bytes come back on registered outputs, each flagged valid for exactly one clock.

Top module: `xbus_sequencer`

## Requirements
- R1: While reset is held, and on the clock after its release, the latch strobe is low, the program-read, read and write strobes (all active-low) are high, the low-port enable is low, and dataCycle, instrValid and rdValid are low. From then on, machine cycles of 12 clocks (phases 0 to 11) follow back to back.
- R2: In a fetch machine cycle the latch strobe is high in phases 0-1 and 6-7, and low otherwise.
- R3: In a fetch machine cycle psenN is low in phases 3-5 and 9-11, and high otherwise.
- R4: In each fetch slot (phases 0-2 and 6-8) the low port is enabled and carries the low byte of the fetch address. Throughout the fetch cycle the high port carries the high byte of that address. The address is sampled at the clock edge that starts the slot.
- R5: The low-port enable is low while psenN is low. lowIn is sampled at the edge that ends the last psenN-low clock. instrValid is high for the one following clock, with instrByte equal to that sample.
- R6: dataReq, dataWrite, dataWide, dataAddr, wrData and p2Sfr are sampled only at the edge that ends phase 11, or at the first edge after reset. If dataReq is 1 there, the next machine cycle is a data cycle (dataWrite 1 = write, 0 = read), and dataCycle is high for all 12 of its clocks. Values at other edges have no effect.
- R7: A data cycle has exactly one latch pulse (phases 0-1) and no psenN pulse.
- R8: In a read cycle rdN is low in phases 4-9. The low port is enabled with the data address low byte in phases 0-2 and released in phases 3-11. lowIn is captured at the edge ending phase 9, and rdValid is high in phase 10 only, with rdByte equal to that capture.
- R9: In a write cycle wrN is low in phases 4-9. The low port is enabled in phases 0-10, carrying the data address low byte in phases 0-2 and the write data in phases 3-10. It is released in phase 11.
- R10: Throughout a data cycle the high port carries the data address high byte when dataWide was 1, and the sampled p2Sfr value when dataWide was 0.
- R11: A fetch cycle right after a data cycle uses the fetch address sampled at that cycle boundary. A request held across a boundary yields consecutive data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchAddr | input | 2*BYTE_W | Program fetch address |
| dataReq | input | 1 | Data access request, sampled at cycle boundary |
| dataWrite | input | 1 | 1 = write, 0 = read |
| dataWide | input | 1 | 1 = full address on high port, 0 = p2Sfr |
| dataAddr | input | 2*BYTE_W | Data access address |
| wrData | input | BYTE_W | Write data |
| p2Sfr | input | BYTE_W | High-port register value for short-form access |
| lowIn | input | BYTE_W | Value read from the low port pins |
| aleOut | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program read strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| lowOut | output | BYTE_W | Low port drive value |
| lowOe | output | 1 | Low port output enable |
| highOut | output | BYTE_W | High port drive value |
| dataCycle | output | 1 | High during a data machine cycle |
| instrByte | output | BYTE_W | Captured instruction byte |
| instrValid | output | 1 | instrByte valid, one clock |
| rdByte | output | BYTE_W | Captured read data |
| rdValid | output | 1 | rdByte valid, one clock |

## Verification
The bench builds the block with BYTE_W set to 4, so that an address is eight bits wide. This makes it feasible to sweep every high-address value through all four access forms: read and write, each in full and short address form. Requests are scheduled in pairs separated by a fetch cycle, which covers back-to-back data cycles and the return to fetching. Spurious request values are driven on every clock that is not a cycle boundary, to show that they are ignored. The fetch address and the value on lowIn change on every clock, so a capture or sample taken one clock early or late gives a wrong byte.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
  localparam int CYC_LEN    = 12;
  localparam int SLOT_LEN   = CYC_LEN / 2;
  localparam int PH_W       = $clog2(CYC_LEN);
  localparam int ALE_LEN    = 2;
  localparam int ADDR_LEN   = 3;
  localparam int PSEN_FIRST = 3;
  localparam int STRB_FIRST = 4;
  localparam int STRB_LAST  = 9;
  localparam int WDATA_LAST = 10;

  typedef enum logic [1:0] {
    KIND_IDLE, KIND_FETCH, KIND_READ, KIND_WRITE
  } cycKind_t;

  typedef enum logic [1:0] {
    LOW_FETCH_ADDR, LOW_DATA_ADDR, LOW_WDATA
  } lowSel_t;

  typedef struct packed {
    logic    aleOn;
    logic    psenOn;
    logic    rdOn;
    logic    wrOn;
    logic    lowOe;
    lowSel_t lowSel;
    logic    dataHigh;
    logic    loadFetch;
    logic    loadData;
    logic    capInstr;
    logic    capRd;
  } busCtl_t;
endpackage

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
module xbus_ctrl
  import xbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dataReq,
  input  logic    dataWrite,
  output busCtl_t ctl,
  output logic    dataCycle
);
  localparam logic [PH_W-1:0] PH_LAST    = PH_W'(CYC_LEN - 1);
  localparam logic [PH_W-1:0] SLOT_PH    = PH_W'(SLOT_LEN);
  localparam logic [PH_W-1:0] SLOT_LAST  = PH_W'(SLOT_LEN - 1);
  localparam logic [PH_W-1:0] ALE_PH     = PH_W'(ALE_LEN);
  localparam logic [PH_W-1:0] ADDR_PH    = PH_W'(ADDR_LEN);
  localparam logic [PH_W-1:0] PSEN_PH    = PH_W'(PSEN_FIRST);
  localparam logic [PH_W-1:0] STRB_F_PH  = PH_W'(STRB_FIRST);
  localparam logic [PH_W-1:0] STRB_L_PH  = PH_W'(STRB_LAST);
  localparam logic [PH_W-1:0] WDATA_L_PH = PH_W'(WDATA_LAST);

  logic [PH_W-1:0] phQ;
  logic [PH_W-1:0] slotPh;
  cycKind_t        kindQ;
  cycKind_t        nextKind;
  logic            lastPh;

  always_comb begin
    slotPh   = (phQ >= SLOT_PH) ? phQ - SLOT_PH : phQ;
    lastPh   = (phQ == PH_LAST);
    nextKind = dataReq ? (dataWrite ? KIND_WRITE : KIND_READ) : KIND_FETCH;
    dataCycle = (kindQ == KIND_READ) || (kindQ == KIND_WRITE);

    ctl           = '0;
    ctl.loadFetch = (slotPh == SLOT_LAST);
    ctl.loadData  = lastPh && dataReq;
    case (kindQ)
      KIND_FETCH: begin
        ctl.aleOn    = slotPh < ALE_PH;
        ctl.lowOe    = slotPh < ADDR_PH;
        ctl.psenOn   = slotPh >= PSEN_PH;
        ctl.lowSel   = LOW_FETCH_ADDR;
        ctl.capInstr = (slotPh == SLOT_LAST);
      end
      KIND_READ: begin
        ctl.aleOn    = phQ < ALE_PH;
        ctl.lowOe    = phQ < ADDR_PH;
        ctl.rdOn     = (phQ >= STRB_F_PH) && (phQ <= STRB_L_PH);
        ctl.lowSel   = LOW_DATA_ADDR;
        ctl.dataHigh = 1'b1;
        ctl.capRd    = (phQ == STRB_L_PH);
      end
      KIND_WRITE: begin
        ctl.aleOn    = phQ < ALE_PH;
        ctl.lowOe    = phQ <= WDATA_L_PH;
        ctl.wrOn     = (phQ >= STRB_F_PH) && (phQ <= STRB_L_PH);
        ctl.lowSel   = (phQ < ADDR_PH) ? LOW_DATA_ADDR : LOW_WDATA;
        ctl.dataHigh = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phQ   <= PH_LAST;
      kindQ <= KIND_IDLE;
    end else if (lastPh) begin
      phQ   <= '0;
      kindQ <= nextKind;
    end else begin
      phQ   <= phQ + PH_W'(1);
    end
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (phQ == '0) |-> ($past(phQ) == PH_LAST)); // R1
  AST_ALE_SLOT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.aleOn) |-> (phQ == '0 || phQ == SLOT_PH)); // R2
  AST_ONE_READ_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.psenOn, ctl.rdOn, ctl.wrOn})); // R7
  AST_DATA_SINGLE_ALE: assert property (@(posedge clk) disable iff (!rstN)
    (dataCycle && phQ >= SLOT_PH) |-> !ctl.aleOn); // R7
  AST_STRB_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.rdOn || ctl.wrOn) |-> (phQ == STRB_F_PH)); // R8
  AST_STRB_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.rdOn || ctl.wrOn) |-> (phQ == WDATA_L_PH)); // R9
endmodule

// File: rtl/xbus_datapath.sv
`timescale 1ns/1ps
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busCtl_t               ctl,
  input  logic [2*BYTE_W-1:0]   fetchAddr,
  input  logic                  dataWide,
  input  logic [2*BYTE_W-1:0]   dataAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [BYTE_W-1:0]     p2Sfr,
  input  logic [BYTE_W-1:0]     lowIn,
  output logic                  aleOut,
  output logic                  psenN,
  output logic                  rdN,
  output logic                  wrN,
  output logic [BYTE_W-1:0]     lowOut,
  output logic                  lowOe,
  output logic [BYTE_W-1:0]     highOut,
  output logic [BYTE_W-1:0]     instrByte,
  output logic                  instrValid,
  output logic [BYTE_W-1:0]     rdByte,
  output logic                  rdValid
);
  localparam int ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] fetchAddrQ;
  logic [ADDR_W-1:0] dataAddrQ;
  logic [BYTE_W-1:0] wrDataQ;
  logic [BYTE_W-1:0] p2Q;
  logic              wideQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchAddrQ <= '0;
      dataAddrQ  <= '0;
      wrDataQ    <= '0;
      p2Q        <= '0;
      wideQ      <= 1'b0;
    end else begin
      if (ctl.loadFetch) fetchAddrQ <= fetchAddr;
      if (ctl.loadData) begin
        dataAddrQ <= dataAddr;
        wrDataQ   <= wrData;
        p2Q       <= p2Sfr;
        wideQ     <= dataWide;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrByte  <= '0;
      instrValid <= 1'b0;
      rdByte     <= '0;
      rdValid    <= 1'b0;
    end else begin
      instrValid <= ctl.capInstr;
      rdValid    <= ctl.capRd;
      if (ctl.capInstr) instrByte <= lowIn;
      if (ctl.capRd)    rdByte    <= lowIn;
    end
  end

  always_comb begin
    aleOut = ctl.aleOn;
    psenN  = !ctl.psenOn;
    rdN    = !ctl.rdOn;
    wrN    = !ctl.wrOn;
    lowOe  = ctl.lowOe;
    case (ctl.lowSel)
      LOW_DATA_ADDR: lowOut = dataAddrQ[BYTE_W-1:0];
      LOW_WDATA:     lowOut = wrDataQ;
      default:       lowOut = fetchAddrQ[BYTE_W-1:0];
    endcase
    if (ctl.dataHigh) highOut = wideQ ? dataAddrQ[ADDR_W-1:BYTE_W] : p2Q;
    else              highOut = fetchAddrQ[ADDR_W-1:BYTE_W];
  end

  AST_FLOAT_UNDER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!psenN || !rdN) |-> !lowOe); // R5
  AST_ADDR_UNDER_ALE: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |-> lowOe); // R4
  AST_INSTR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> !instrValid); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R8
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (lowOe && lowOut == wrDataQ)); // R9
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dataHigh && $past(ctl.dataHigh) && !$past(ctl.loadData)) |-> $stable(highOut)); // R10
endmodule

// File: rtl/xbus_sequencer.sv
`timescale 1ns/1ps
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*BYTE_W-1:0]   fetchAddr,
  input  logic                  dataReq,
  input  logic                  dataWrite,
  input  logic                  dataWide,
  input  logic [2*BYTE_W-1:0]   dataAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [BYTE_W-1:0]     p2Sfr,
  input  logic [BYTE_W-1:0]     lowIn,
  output logic                  aleOut,
  output logic                  psenN,
  output logic                  rdN,
  output logic                  wrN,
  output logic [BYTE_W-1:0]     lowOut,
  output logic                  lowOe,
  output logic [BYTE_W-1:0]     highOut,
  output logic                  dataCycle,
  output logic [BYTE_W-1:0]     instrByte,
  output logic                  instrValid,
  output logic [BYTE_W-1:0]     rdByte,
  output logic                  rdValid
);
  busCtl_t ctl;

  xbus_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .dataReq   (dataReq),
    .dataWrite (dataWrite),
    .ctl       (ctl),
    .dataCycle (dataCycle)
  );

  xbus_datapath #(.BYTE_W(BYTE_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .fetchAddr  (fetchAddr),
    .dataWide   (dataWide),
    .dataAddr   (dataAddr),
    .wrData     (wrData),
    .p2Sfr      (p2Sfr),
    .lowIn      (lowIn),
    .aleOut     (aleOut),
    .psenN      (psenN),
    .rdN        (rdN),
    .wrN        (wrN),
    .lowOut     (lowOut),
    .lowOe      (lowOe),
    .highOut    (highOut),
    .instrByte  (instrByte),
    .instrValid (instrValid),
    .rdByte     (rdByte),
    .rdValid    (rdValid)
  );
endmodule

// File: tb/tb_xbus_sequencer.sv
`timescale 1ns/1ps
module tb_xbus_sequencer;
  localparam int BW   = 4;
  localparam int AW   = 2 * BW;
  localparam int BM   = (1 << BW) - 1;
  localparam int AM   = (1 << AW) - 1;
  localparam int NREQ = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN;
  logic [AW-1:0] fetchAddr, dataAddr;
  logic          dataReq, dataWrite, dataWide;
  logic [BW-1:0] wrData, p2Sfr, lowIn;
  logic          aleOut, psenN, rdN, wrN, lowOe, dataCycle, instrValid, rdValid;
  logic [BW-1:0] lowOut, highOut, instrByte, rdByte;

  xbus_sequencer #(.BYTE_W(BW)) dut (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .dataReq(dataReq),
    .dataWrite(dataWrite), .dataWide(dataWide), .dataAddr(dataAddr),
    .wrData(wrData), .p2Sfr(p2Sfr), .lowIn(lowIn), .aleOut(aleOut),
    .psenN(psenN), .rdN(rdN), .wrN(wrN), .lowOut(lowOut), .lowOe(lowOe),
    .highOut(highOut), .dataCycle(dataCycle), .instrByte(instrByte),
    .instrValid(instrValid), .rdByte(rdByte), .rdValid(rdValid)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench model: 0 idle, 1 fetch, 2 read, 3 write
  int mKind = 0, mPh = 11;
  int mFA = 0, mDA = 0, mWD = 0, mWide = 0, mP2 = 0;
  int eInstrV = 0, eInstrB = 0, eRdV = 0, eRdB = 0;
  int afterData = 0;
  int bnd = 0, reqIdx = 0;

  task automatic checkOutputs();
    int s = mPh % 6;
    string kt;
    string ft;
    int eAle = 0, ePsen = 0, eRd = 0, eWr = 0, eOe = 0, eLow = 0, eHigh = 0;
    ft = afterData ? "R11" : "R4";
    case (mKind)
      1: begin
        eAle = (s < 2); ePsen = (s >= 3); eOe = (s < 3);
        eLow = mFA & BM; eHigh = (mFA >> BW) & BM; kt = "R2";
      end
      2: begin
        eAle = (mPh < 2); eRd = (mPh >= 4 && mPh <= 9); eOe = (mPh < 3);
        eLow = mDA & BM; kt = "R7";
      end
      3: begin
        eAle = (mPh < 2); eWr = (mPh >= 4 && mPh <= 9); eOe = (mPh <= 10);
        eLow = (mPh < 3) ? (mDA & BM) : mWD; kt = "R7";
      end
      default: kt = "R1";
    endcase
    if (mKind >= 2) eHigh = mWide ? ((mDA >> BW) & BM) : mP2;

    chk(kt, "aleOut", int'(aleOut), eAle);
    chk(mKind == 1 ? "R3" : kt, "psenN", int'(psenN), ePsen ? 0 : 1);
    chk(mKind == 0 ? "R1" : "R8", "rdN", int'(rdN), eRd ? 0 : 1);
    chk(mKind == 0 ? "R1" : "R9", "wrN", int'(wrN), eWr ? 0 : 1);
    chk(mKind == 1 ? "R5" : (mKind == 2 ? "R8" : (mKind == 3 ? "R9" : "R1")),
        "lowOe", int'(lowOe), eOe);
    if (eOe) chk(mKind == 1 ? ft : (mKind == 2 ? "R8" : "R9"), "lowOut", int'(lowOut), eLow);
    if (mKind == 1) chk(ft, "highOut", int'(highOut), eHigh);
    if (mKind >= 2) chk("R10", "highOut", int'(highOut), eHigh);
    chk(mKind == 0 ? "R1" : "R6", "dataCycle", int'(dataCycle), (mKind >= 2) ? 1 : 0);
    chk("R5", "instrValid", int'(instrValid), eInstrV);
    if (eInstrV) chk("R5", "instrByte", int'(instrByte), eInstrB);
    chk("R8", "rdValid", int'(rdValid), eRdV);
    if (eRdV) chk("R8", "rdByte", int'(rdByte), eRdB);
  endtask

  task automatic driveInputs(input int cyc);
    bit boundary = (mKind == 0) || (mPh == 11);
    fetchAddr = AW'((cyc * 37 + 11) & AM);
    lowIn     = BW'((cyc * 3 + 1) & BM);
    if (boundary) begin
      if ((bnd % 3) != 2 && reqIdx < NREQ) begin
        // R6: request sweep, high nibble from reqIdx, form from low two bits
        int hi = (reqIdx >> 2) & BM;
        int lo = (reqIdx * 7 + 3) & BM;
        dataReq   = 1'b1;
        dataWrite = reqIdx[0];
        dataWide  = reqIdx[1];
        dataAddr  = AW'((hi << BW) | lo);
        wrData    = BW'((reqIdx * 5 + 1) & BM);
        p2Sfr     = BW'(hi ^ 10);
        reqIdx++;
      end else begin
        dataReq   = 1'b0;
        dataWrite = cyc[0];
        dataWide  = cyc[1];
        dataAddr  = AW'((cyc * 13) & AM);
        wrData    = BW'((cyc * 7) & BM);
        p2Sfr     = BW'((cyc * 5) & BM);
      end
      bnd++;
    end else begin
      // R6: noise away from the boundary must be ignored
      dataReq   = cyc[0];
      dataWrite = cyc[1];
      dataWide  = cyc[2];
      dataAddr  = AW'((cyc * 29 + 5) & AM);
      wrData    = BW'((cyc * 11) & BM);
      p2Sfr     = BW'((cyc * 9 + 2) & BM);
    end
  endtask

  task automatic advanceModel();
    int s = mPh % 6;
    int oldKind = mKind;
    eInstrV = (mKind == 1 && s == 5) ? 1 : 0;
    if (eInstrV) eInstrB = int'(lowIn);
    eRdV = (mKind == 2 && mPh == 9) ? 1 : 0;
    if (eRdV) eRdB = int'(lowIn);
    if (s == 5) mFA = int'(fetchAddr);
    if (mKind == 0 || mPh == 11) begin
      mPh = 0;
      if (dataReq) begin
        mKind = dataWrite ? 3 : 2;
        mDA = int'(dataAddr); mWD = int'(wrData);
        mWide = int'(dataWide); mP2 = int'(p2Sfr);
      end else begin
        mKind = 1;
      end
      afterData = (oldKind >= 2 && mKind == 1) ? 1 : 0;
    end else begin
      mPh++;
    end
  endtask

  initial begin
    rstN = 1'b0; fetchAddr = '0; dataReq = 1'b0; dataWrite = 1'b0; dataWide = 1'b0;
    dataAddr = '0; wrData = '0; p2Sfr = '0; lowIn = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    checkOutputs();
    rstN = 1'b1;
    for (int cyc = 0; cyc < 101 * 12; cyc++) begin
      if (cyc > 0) checkOutputs();
      driveInputs(cyc);
      advanceModel();
      @(negedge clk);
    end
    chk("R6", "requests issued", reqIdx, NREQ);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(60000 * 5);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule